// File: doc/BRIEF.md
# Pending-Acknowledgement Completion Tracker

This block keeps, for each of a small set of outstanding coherence transactions, a signed count of the acknowledgement and data messages still owed. A slot is opened with an allocate strobe, which starts its count at zero. Every later update strobe carries a signed ack value that is subtracted from the addressed slot's count. A peer cache's acknowledgement carries minus one and so raises the count. The owner's data, or the requester's own exclusive request coming back, carries the expected total and lowers it. The count may therefore go negative before it settles.

When an update leaves a slot's count at exactly zero, the slot posts one completion trigger. Triggers from all slots are offered one at a time on a valid/ready output toward the coherence controller, lowest slot index first. Closing a slot clears its count and discards any trigger it has not yet delivered. Updates aimed at a closed slot, and results that do not fit the signed count width, are reported on one-cycle error pulses.

Top module: `ack_tracker`

## Requirements
- R1: During and right after reset, trig_valid, err_range and err_unalloc are all 0.
- R2: Allocating a slot sets its count to zero and does not post a trigger by itself; with no update strobe, trig_valid never rises.
- R3: An update to a live slot subtracts upd_acks (two's complement, ACK_W bits) from the count. If the result is zero, trig_valid is 1 and trig_slot names that slot from the edge after the update.
- R4: An update value of -1 increments the count. The count may pass through negative values, and a trigger appears only when it reaches exactly zero.
- R5: A posted trigger stays offered while trig_ready is 0. It is removed by the edge at which trig_valid and trig_ready are both 1, and one zero result yields only one trigger.
- R6: When several slots hold triggers, the lowest-indexed slot is offered first.
- R7: Deallocating a slot discards its pending trigger and returns it to the closed state, so a later update to it is flagged as unallocated.
- R8: An update to a slot that is not allocated changes nothing and raises err_unalloc for exactly one cycle, starting at the edge after the update.
- R9: An update whose result lies outside the signed ACK_W-bit range leaves the count unchanged and raises err_range for one cycle.
- R10: An allocate and an update to the same slot in the same cycle: the allocate wins, the update is dropped, and no error is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_en | input | 1 | Open a slot |
| alloc_slot | input | IDX_W | Slot to open |
| dealloc_en | input | 1 | Close a slot |
| dealloc_slot | input | IDX_W | Slot to close |
| upd_en | input | 1 | Apply an ack value |
| upd_slot | input | IDX_W | Slot to update |
| upd_acks | input | ACK_W | Signed value subtracted from the count |
| trig_valid | output | 1 | A completion trigger is offered |
| trig_slot | output | IDX_W | Slot of the offered trigger |
| trig_ready | input | 1 | Controller takes the offered trigger |
| err_range | output | 1 | Last update overflowed the count range |
| err_unalloc | output | 1 | Last update addressed a closed slot |

## Verification
Every result of this block lands exactly one clock edge after the stimulus. A zero-reaching update shows on trig_valid after that edge, a pop clears the offer after its edge, and both error pulses appear after the edge of the offending update and vanish one edge later. The bench drives strobes on the falling clock edge for one cycle and reads outputs on the next falling edge, so each check samples one edge after its stimulus. Where it must confirm that nothing appeared or that a pulse ended, it reads again one falling edge later.

// File: rtl/ack_tracker_pkg.sv
package ack_tracker_pkg;

    localparam int ACK_W     = 8;
    localparam int DEF_SLOTS = 4;

    typedef logic signed [ACK_W-1:0] ack_t;

    typedef struct packed {
        logic live;
        ack_t cnt;
        logic pend;
    } slot_state_t;

    typedef struct packed {
        logic ovf;
        ack_t val;
    } sub_res_t;

    // Signed subtraction with one guard bit; overflow when the guard disagrees
    function automatic sub_res_t sub_acks(ack_t cur, ack_t dec);
        logic signed [ACK_W:0] wide;
        sub_res_t r;
        wide  = {cur[ACK_W-1], cur} - {dec[ACK_W-1], dec};
        r.ovf = wide[ACK_W] ^ wide[ACK_W-1];
        r.val = wide[ACK_W-1:0];
        return r;
    endfunction

endpackage

// File: rtl/ack_slot.sv
module ack_slot
    import ack_tracker_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic alloc,
    input  logic dealloc,
    input  logic upd,
    input  ack_t acks,
    input  logic pop,
    output logic pend,
    output logic err_rng,
    output logic err_unal
);

    slot_state_t st;
    sub_res_t    res;
    logic        apply;

    always_comb begin
        res      = sub_acks(st.cnt, acks);
        apply    = upd && !alloc && !dealloc && st.live && !res.ovf;
        err_rng  = upd && !alloc && !dealloc && st.live && res.ovf;
        err_unal = upd && !alloc && !st.live;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else if (alloc) begin
            st.live <= 1'b1;
            st.cnt  <= '0;
            st.pend <= 1'b0;
        end else if (dealloc) begin
            st <= '0;
        end else begin
            if (apply) st.cnt <= res.val;
            st.pend <= (st.pend && !pop) || (apply && (res.val == '0));
        end
    end

    assign pend = st.pend;

endmodule

// File: rtl/ack_pick.sv
module ack_pick #(
    parameter int N     = 4,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req,
    output logic             valid,
    output logic [IDX_W-1:0] idx
);

    always_comb begin
        valid = |req;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/ack_tracker.sv
module ack_tracker
    import ack_tracker_pkg::*;
#(
    parameter int NUM_SLOTS = DEF_SLOTS,
    localparam int IDX_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             alloc_en,
    input  logic [IDX_W-1:0] alloc_slot,
    input  logic             dealloc_en,
    input  logic [IDX_W-1:0] dealloc_slot,
    input  logic             upd_en,
    input  logic [IDX_W-1:0] upd_slot,
    input  logic [ACK_W-1:0] upd_acks,
    output logic             trig_valid,
    output logic [IDX_W-1:0] trig_slot,
    input  logic             trig_ready,
    output logic             err_range,
    output logic             err_unalloc
);

    logic [NUM_SLOTS-1:0] pend_vec;
    logic [NUM_SLOTS-1:0] rng_vec;
    logic [NUM_SLOTS-1:0] unal_vec;
    logic                 pop;

    assign pop = trig_valid && trig_ready;

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        ack_slot u_slot (
            .clk      (clk),
            .rst      (rst),
            .alloc    (alloc_en   && (alloc_slot   == IDX_W'(g))),
            .dealloc  (dealloc_en && (dealloc_slot == IDX_W'(g))),
            .upd      (upd_en     && (upd_slot     == IDX_W'(g))),
            .acks     (ack_t'(upd_acks)),
            .pop      (pop && (trig_slot == IDX_W'(g))),
            .pend     (pend_vec[g]),
            .err_rng  (rng_vec[g]),
            .err_unal (unal_vec[g])
        );
    end

    ack_pick #(.N(NUM_SLOTS), .IDX_W(IDX_W)) u_pick (
        .req   (pend_vec),
        .valid (trig_valid),
        .idx   (trig_slot)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            err_range   <= 1'b0;
            err_unalloc <= 1'b0;
        end else begin
            err_range   <= |rng_vec;
            err_unalloc <= |unal_vec;
        end
    end

endmodule

// File: rtl/ack_tracker_chk.sv
module ack_tracker_chk #(
    parameter int NUM_SLOTS = 4,
    parameter int IDX_W     = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             alloc_en,
    input logic [IDX_W-1:0] alloc_slot,
    input logic             dealloc_en,
    input logic             upd_en,
    input logic [IDX_W-1:0] upd_slot,
    input logic             trig_valid,
    input logic             trig_ready,
    input logic             err_range,
    input logic             err_unalloc
);

    p_trig_hold_r5: assert property (@(posedge clk) disable iff (rst)
        trig_valid && !trig_ready && !dealloc_en |=> trig_valid);

    p_no_spont_trig_r2: assert property (@(posedge clk) disable iff (rst)
        !upd_en && !trig_valid |=> !trig_valid);

    p_unal_cause_r8: assert property (@(posedge clk) disable iff (rst)
        err_unalloc |-> $past(upd_en));

    p_range_cause_r9: assert property (@(posedge clk) disable iff (rst)
        err_range |-> $past(upd_en));

    p_err_excl_r9: assert property (@(posedge clk) disable iff (rst)
        !(err_range && err_unalloc));

    p_alloc_wins_r10: assert property (@(posedge clk) disable iff (rst)
        alloc_en && upd_en && (alloc_slot == upd_slot) |=> !err_unalloc && !err_range);

endmodule

bind ack_tracker ack_tracker_chk #(.NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .alloc_en    (alloc_en),
    .alloc_slot  (alloc_slot),
    .dealloc_en  (dealloc_en),
    .upd_en      (upd_en),
    .upd_slot    (upd_slot),
    .trig_valid  (trig_valid),
    .trig_ready  (trig_ready),
    .err_range   (err_range),
    .err_unalloc (err_unalloc)
);

// File: tb/ack_tracker_bench.sv
module ack_tracker_bench;
    localparam int NS = 4;
    localparam int IW = 2;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          alloc_en = 0, dealloc_en = 0, upd_en = 0, trig_ready = 0;
    logic [IW-1:0] alloc_slot = '0, dealloc_slot = '0, upd_slot = '0;
    logic [AW-1:0] upd_acks = '0;
    logic          trig_valid, err_range, err_unalloc;
    logic [IW-1:0] trig_slot;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    ack_tracker #(.NUM_SLOTS(NS)) u_ack_tracker (
        .clk(clk), .rst(rst),
        .alloc_en(alloc_en), .alloc_slot(alloc_slot),
        .dealloc_en(dealloc_en), .dealloc_slot(dealloc_slot),
        .upd_en(upd_en), .upd_slot(upd_slot), .upd_acks(upd_acks),
        .trig_valid(trig_valid), .trig_slot(trig_slot), .trig_ready(trig_ready),
        .err_range(err_range), .err_unalloc(err_unalloc)
    );

    task automatic chk(string req, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    task automatic do_alloc(int s);
        alloc_en = 1; alloc_slot = IW'(s);
        @(negedge clk);
        alloc_en = 0;
    endtask

    task automatic do_dealloc(int s);
        dealloc_en = 1; dealloc_slot = IW'(s);
        @(negedge clk);
        dealloc_en = 0;
    endtask

    task automatic do_upd(int s, int a);
        upd_en = 1; upd_slot = IW'(s); upd_acks = AW'(a);
        @(negedge clk);
        upd_en = 0;
    endtask

    task automatic do_pop();
        trig_ready = 1;
        @(negedge clk);
        trig_ready = 0;
    endtask

    task automatic t_reset();
        chk("R1 trig_valid in reset", int'(trig_valid), 0);
        rst = 0;
        idle();
        chk("R1 trig_valid after reset", int'(trig_valid), 0);
        chk("R1 err_range after reset", int'(err_range), 0);
        chk("R1 err_unalloc after reset", int'(err_unalloc), 0);
    endtask

    task automatic t_basic();
        do_alloc(0);
        chk("R2 no trigger from alloc", int'(trig_valid), 0);
        do_upd(0, 2);
        chk("R3 count -2 no trigger", int'(trig_valid), 0);
        do_upd(0, -1);
        do_upd(0, -1);
        chk("R3 zero posts trigger", int'(trig_valid), 1);
        chk("R3 trigger slot", int'(trig_slot), 0);
        do_pop();
        chk("R5 pop clears trigger", int'(trig_valid), 0);
        idle(); idle();
        chk("R5 single trigger per zero", int'(trig_valid), 0);
        do_dealloc(0);
    endtask

    task automatic t_negative();
        do_alloc(1);
        do_upd(1, -1);
        do_upd(1, -1);
        chk("R4 count 2 no trigger", int'(trig_valid), 0);
        do_upd(1, 3);
        chk("R4 count -1 no trigger", int'(trig_valid), 0);
        do_upd(1, -1);
        chk("R4 settles at zero", int'(trig_valid), 1);
        chk("R4 slot", int'(trig_slot), 1);
        do_pop();
        do_dealloc(1);
    endtask

    task automatic t_handshake();
        do_alloc(2);
        do_upd(2, 0);
        for (int i = 0; i < 3; i++) begin
            idle();
            chk("R5 held without ready", int'(trig_valid), 1);
            chk("R5 held slot", int'(trig_slot), 2);
        end
        do_pop();
        chk("R5 removed by pop", int'(trig_valid), 0);
        do_dealloc(2);
    endtask

    task automatic t_priority();
        do_alloc(3);
        do_alloc(1);
        do_upd(3, 0);
        do_upd(1, 0);
        chk("R6 lowest first", int'(trig_slot), 1);
        do_pop();
        chk("R6 second valid", int'(trig_valid), 1);
        chk("R6 second slot", int'(trig_slot), 3);
        do_pop();
        chk("R6 all drained", int'(trig_valid), 0);
        do_dealloc(3);
        do_dealloc(1);
    endtask

    task automatic t_dealloc();
        do_alloc(0);
        do_upd(0, 0);
        chk("R7 trigger before close", int'(trig_valid), 1);
        do_dealloc(0);
        chk("R7 close discards trigger", int'(trig_valid), 0);
        do_upd(0, 0);
        chk("R7 closed slot flagged", int'(err_unalloc), 1);
        chk("R7 closed slot no trigger", int'(trig_valid), 0);
        idle();
    endtask

    task automatic t_unalloc();
        do_upd(2, 0);
        chk("R8 err_unalloc raised", int'(err_unalloc), 1);
        chk("R8 no trigger", int'(trig_valid), 0);
        chk("R8 no range error", int'(err_range), 0);
        idle();
        chk("R8 pulse one cycle", int'(err_unalloc), 0);
    endtask

    task automatic t_range();
        do_alloc(0);
        do_upd(0, 100);
        chk("R9 -100 in range", int'(err_range), 0);
        do_upd(0, 100);
        chk("R9 underflow flagged", int'(err_range), 1);
        chk("R9 no trigger on underflow", int'(trig_valid), 0);
        idle();
        chk("R9 pulse one cycle", int'(err_range), 0);
        do_upd(0, -100);
        chk("R9 count unchanged", int'(trig_valid), 1);
        do_pop();
        do_alloc(0);
        do_upd(0, -128);
        chk("R9 overflow flagged", int'(err_range), 1);
        do_dealloc(0);
    endtask

    task automatic t_collision();
        alloc_en = 1; alloc_slot = 2;
        upd_en = 1; upd_slot = 2; upd_acks = 0;
        @(negedge clk);
        alloc_en = 0; upd_en = 0;
        chk("R10 update dropped", int'(trig_valid), 0);
        chk("R10 no unalloc error", int'(err_unalloc), 0);
        chk("R10 no range error", int'(err_range), 0);
        do_upd(2, 0);
        chk("R10 slot open after alloc", int'(trig_valid), 1);
        do_pop();
        do_dealloc(2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_basic();
        t_negative();
        t_handshake();
        t_priority();
        t_dealloc();
        t_unalloc();
        t_range();
        t_collision();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule